// File: doc/BRIEF.md
# Digital Audio Routing Crossbar

This block is a configurable switch that sits between a set of external audio ports and a set of internal audio controllers. Each external port has four lines: bit clock, frame sync and two serial data lines. Each line has its own input, output and output-enable signal. A small word-addressed register bank sets up the routing. Every lookup from register contents to pins is combinational, so audio samples pass through with no added delay.

Routing runs in two independent directions. Each port has its own register, which names the source for that port's outputs. The source is either a controller or another port. When the source is a peer port, two control bits apply: a master/slave bit, and a receive/transmit bit for each data line. Each controller has a register that names which port supplies its clock pair and which port supplies each of its two data inputs. A controller reaches a port only when that port selects it. Several ports can therefore carry one controller at the same time.

The block does not check whether a routing setup is consistent. Source codes that map to no resource disable the port's drivers. Selections of ports that do not exist read as zero.

Top module: `audio_xbar`

## Requirements
- R1: After reset every register reads 0. Every port follows controller 1 with all four output enables high.
- R2: The register for port p sits at byte address 4*p. Bits 4:0 hold the source code: values 0..N_CTRL-1 pick a controller and values 16..16+N_PORT-1 pick a peer port. Bit 29 is the rx flag for data line 2, bit 30 is the rx flag for data line 1 and bit 31 is the master flag. All other bits read 0.
- R3: The input register for controller c sits at byte address 0x40+4*c. Bits 3:0 name the port that supplies clock and frame sync. Bits 27:24 name the port for data input 1 and bits 31:28 name the port for data input 2. All other bits read 0.
- R4: A write changes the register at the rising clock edge that samples reg_we. Read data follows reg_addr combinationally. Addresses that are unaligned or match no register read 0, and writes to them change nothing.
- R5: A port whose source is a controller drives that controller's bit clock and frame sync with the enables high. Each data line whose rx flag is 0 drives the controller's matching data line. A data line whose rx flag is 1 has its enable low and its output 0. Changes on the data path appear in the same cycle.
- R6: Several ports that select the same controller all carry that controller's signals at once.
- R7: A port whose source is peer q and whose master flag is 0 drives port q's incoming bit clock and frame sync, with the enables high.
- R8: A port whose source is a peer and whose master flag is 1 keeps its bit clock and frame sync enables low and its outputs 0.
- R9: On a peer link, a data line whose rx flag is 0 drives port q's incoming line of the same number. A data line whose rx flag is 1 has its enable low.
- R10: Source codes from N_CTRL to 15, and from 16+N_PORT to 31, leave all four enables and outputs of the port at 0.
- R11: Each controller receives bit clock and frame sync from its clock port and each data input from its selected port. A selection of N_PORT or above gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| port_bclk_i | input | N_PORT | Bit clock in, one bit per port |
| port_bclk_o | output | N_PORT | Bit clock out |
| port_bclk_oe | output | N_PORT | Bit clock output enable |
| port_fs_i | input | N_PORT | Frame sync in |
| port_fs_o | output | N_PORT | Frame sync out |
| port_fs_oe | output | N_PORT | Frame sync output enable |
| port_sd1_i | input | N_PORT | Data line 1 in |
| port_sd1_o | output | N_PORT | Data line 1 out |
| port_sd1_oe | output | N_PORT | Data line 1 output enable |
| port_sd2_i | input | N_PORT | Data line 2 in |
| port_sd2_o | output | N_PORT | Data line 2 out |
| port_sd2_oe | output | N_PORT | Data line 2 output enable |
| ctl_bclk_tx | input | N_CTRL | Bit clock from each controller |
| ctl_fs_tx | input | N_CTRL | Frame sync from each controller |
| ctl_sd1_tx | input | N_CTRL | Data 1 from each controller |
| ctl_sd2_tx | input | N_CTRL | Data 2 from each controller |
| ctl_bclk_rx | output | N_CTRL | Bit clock to each controller |
| ctl_fs_rx | output | N_CTRL | Frame sync to each controller |
| ctl_sd1_rx | output | N_CTRL | Data 1 to each controller |
| ctl_sd2_rx | output | N_CTRL | Data 2 to each controller |

## Verification
The bench builds the block with its defaults: five ports, three controllers and an 8-bit address. With these values every gap in the encodings is a distinct case the bench can reach. Source codes 3..15 and 21..31 are invalid, while code 20 is the last valid peer (a port selecting itself). Controller selections 5..15 name ports that do not exist. Addresses 0x14 and 0x4C fall just past each register group, and 0x41 is an unaligned address inside the controller group.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int SRC_W      = 5;
    localparam int SEL_W      = 4;
    localparam int PEER_BASE  = 16;
    localparam int CTRL_WORD  = 16;   // byte 0x40 >> 2

    // port routing word, packed in register bit order (31, 30, 29, 4:0)
    typedef struct packed {
        logic             master;
        logic             sd1_rx;
        logic             sd2_rx;
        logic [SRC_W-1:0] src;
    } port_cfg_t;

    // controller input word: 31:28, 27:24, 3:0
    typedef struct packed {
        logic [SEL_W-1:0] sd2_sel;
        logic [SEL_W-1:0] sd1_sel;
        logic [SEL_W-1:0] clk_sel;
    } ctrl_cfg_t;

endpackage

// File: rtl/xbar_regs.sv
module xbar_regs #(
    parameter int N_PORT = 5,
    parameter int N_CTRL = 3,
    parameter int ADDR_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-1:0]                      reg_addr,
    input  logic                                   reg_we,
    input  logic [31:0]                            reg_wdata,
    output logic [31:0]                            reg_rdata,
    output xbar_pkg::port_cfg_t [N_PORT-1:0]       port_cfg,
    output xbar_pkg::ctrl_cfg_t [N_CTRL-1:0]       ctrl_cfg
);
    import xbar_pkg::*;

    localparam int WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;
    logic [N_PORT-1:0] hit_port;
    logic [N_CTRL-1:0] hit_ctrl;
    logic              unused_wdata;

    assign aligned      = (reg_addr[1:0] == 2'b00);
    assign word         = reg_addr[ADDR_W-1:2];
    assign unused_wdata = ^reg_wdata[23:5];

    always_comb begin
        for (int p = 0; p < N_PORT; p++)
            hit_port[p] = aligned && (word == WORD_W'(p));
        for (int c = 0; c < N_CTRL; c++)
            hit_ctrl[c] = aligned && (word == WORD_W'(CTRL_WORD + c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_cfg <= '0;
            ctrl_cfg <= '0;
        end else if (reg_we) begin
            for (int p = 0; p < N_PORT; p++)
                if (hit_port[p])
                    port_cfg[p] <= {reg_wdata[31], reg_wdata[30], reg_wdata[29],
                                    reg_wdata[SRC_W-1:0]};
            for (int c = 0; c < N_CTRL; c++)
                if (hit_ctrl[c])
                    ctrl_cfg[c] <= {reg_wdata[31:28], reg_wdata[27:24],
                                    reg_wdata[SEL_W-1:0]};
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < N_PORT; p++)
            if (hit_port[p])
                reg_rdata = {port_cfg[p].master, port_cfg[p].sd1_rx,
                             port_cfg[p].sd2_rx, 24'b0, port_cfg[p].src};
        for (int c = 0; c < N_CTRL; c++)
            if (hit_ctrl[c])
                reg_rdata = {ctrl_cfg[c].sd2_sel, ctrl_cfg[c].sd1_sel,
                             20'b0, ctrl_cfg[c].clk_sel};
    end

endmodule

// File: rtl/xbar_port_route.sv
module xbar_port_route #(
    parameter int N_PORT = 5,
    parameter int N_CTRL = 3
) (
    input  xbar_pkg::port_cfg_t cfg,
    input  logic [N_CTRL-1:0]   ctl_bclk_tx,
    input  logic [N_CTRL-1:0]   ctl_fs_tx,
    input  logic [N_CTRL-1:0]   ctl_sd1_tx,
    input  logic [N_CTRL-1:0]   ctl_sd2_tx,
    input  logic [N_PORT-1:0]   port_bclk_i,
    input  logic [N_PORT-1:0]   port_fs_i,
    input  logic [N_PORT-1:0]   port_sd1_i,
    input  logic [N_PORT-1:0]   port_sd2_i,
    output logic                bclk_o,
    output logic                bclk_oe,
    output logic                fs_o,
    output logic                fs_oe,
    output logic                sd1_o,
    output logic                sd1_oe,
    output logic                sd2_o,
    output logic                sd2_oe
);
    import xbar_pkg::*;

    logic src_ok;
    logic clk_drive;
    logic bclk_src, fs_src, sd1_src, sd2_src;

    always_comb begin
        src_ok    = 1'b0;
        clk_drive = 1'b0;
        bclk_src  = 1'b0;
        fs_src    = 1'b0;
        sd1_src   = 1'b0;
        sd2_src   = 1'b0;
        for (int c = 0; c < N_CTRL; c++) begin
            if (cfg.src == SRC_W'(c)) begin
                src_ok    = 1'b1;
                clk_drive = 1'b1;
                bclk_src  = ctl_bclk_tx[c];
                fs_src    = ctl_fs_tx[c];
                sd1_src   = ctl_sd1_tx[c];
                sd2_src   = ctl_sd2_tx[c];
            end
        end
        for (int q = 0; q < N_PORT; q++) begin
            if (cfg.src == SRC_W'(PEER_BASE + q)) begin
                src_ok    = 1'b1;
                clk_drive = !cfg.master;
                bclk_src  = port_bclk_i[q];
                fs_src    = port_fs_i[q];
                sd1_src   = port_sd1_i[q];
                sd2_src   = port_sd2_i[q];
            end
        end
    end

    always_comb begin
        bclk_oe = clk_drive;
        fs_oe   = clk_drive;
        sd1_oe  = src_ok && !cfg.sd1_rx;
        sd2_oe  = src_ok && !cfg.sd2_rx;
        bclk_o  = bclk_oe && bclk_src;
        fs_o    = fs_oe && fs_src;
        sd1_o   = sd1_oe && sd1_src;
        sd2_o   = sd2_oe && sd2_src;
    end

endmodule

// File: rtl/xbar_ctrl_route.sv
module xbar_ctrl_route #(
    parameter int N_PORT = 5
) (
    input  xbar_pkg::ctrl_cfg_t cfg,
    input  logic [N_PORT-1:0]   port_bclk_i,
    input  logic [N_PORT-1:0]   port_fs_i,
    input  logic [N_PORT-1:0]   port_sd1_i,
    input  logic [N_PORT-1:0]   port_sd2_i,
    output logic                bclk_rx,
    output logic                fs_rx,
    output logic                sd1_rx,
    output logic                sd2_rx
);
    import xbar_pkg::*;

    always_comb begin
        bclk_rx = 1'b0;
        fs_rx   = 1'b0;
        sd1_rx  = 1'b0;
        sd2_rx  = 1'b0;
        for (int q = 0; q < N_PORT; q++) begin
            if (cfg.clk_sel == SEL_W'(q)) begin
                bclk_rx = port_bclk_i[q];
                fs_rx   = port_fs_i[q];
            end
            if (cfg.sd1_sel == SEL_W'(q))
                sd1_rx = port_sd1_i[q];
            if (cfg.sd2_sel == SEL_W'(q))
                sd2_rx = port_sd2_i[q];
        end
    end

endmodule

// File: rtl/audio_xbar.sv
module audio_xbar #(
    parameter int N_PORT = 5,
    parameter int N_CTRL = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_PORT-1:0] port_bclk_i,
    output logic [N_PORT-1:0] port_bclk_o,
    output logic [N_PORT-1:0] port_bclk_oe,
    input  logic [N_PORT-1:0] port_fs_i,
    output logic [N_PORT-1:0] port_fs_o,
    output logic [N_PORT-1:0] port_fs_oe,
    input  logic [N_PORT-1:0] port_sd1_i,
    output logic [N_PORT-1:0] port_sd1_o,
    output logic [N_PORT-1:0] port_sd1_oe,
    input  logic [N_PORT-1:0] port_sd2_i,
    output logic [N_PORT-1:0] port_sd2_o,
    output logic [N_PORT-1:0] port_sd2_oe,
    input  logic [N_CTRL-1:0] ctl_bclk_tx,
    input  logic [N_CTRL-1:0] ctl_fs_tx,
    input  logic [N_CTRL-1:0] ctl_sd1_tx,
    input  logic [N_CTRL-1:0] ctl_sd2_tx,
    output logic [N_CTRL-1:0] ctl_bclk_rx,
    output logic [N_CTRL-1:0] ctl_fs_rx,
    output logic [N_CTRL-1:0] ctl_sd1_rx,
    output logic [N_CTRL-1:0] ctl_sd2_rx
);
    import xbar_pkg::*;

    port_cfg_t [N_PORT-1:0] port_cfg;
    ctrl_cfg_t [N_CTRL-1:0] ctrl_cfg;

    xbar_regs #(
        .N_PORT (N_PORT),
        .N_CTRL (N_CTRL),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .port_cfg  (port_cfg),
        .ctrl_cfg  (ctrl_cfg)
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        xbar_port_route #(
            .N_PORT (N_PORT),
            .N_CTRL (N_CTRL)
        ) u_route (
            .cfg         (port_cfg[p]),
            .ctl_bclk_tx (ctl_bclk_tx),
            .ctl_fs_tx   (ctl_fs_tx),
            .ctl_sd1_tx  (ctl_sd1_tx),
            .ctl_sd2_tx  (ctl_sd2_tx),
            .port_bclk_i (port_bclk_i),
            .port_fs_i   (port_fs_i),
            .port_sd1_i  (port_sd1_i),
            .port_sd2_i  (port_sd2_i),
            .bclk_o      (port_bclk_o[p]),
            .bclk_oe     (port_bclk_oe[p]),
            .fs_o        (port_fs_o[p]),
            .fs_oe       (port_fs_oe[p]),
            .sd1_o       (port_sd1_o[p]),
            .sd1_oe      (port_sd1_oe[p]),
            .sd2_o       (port_sd2_o[p]),
            .sd2_oe      (port_sd2_oe[p])
        );
    end

    for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
        xbar_ctrl_route #(
            .N_PORT (N_PORT)
        ) u_route (
            .cfg         (ctrl_cfg[c]),
            .port_bclk_i (port_bclk_i),
            .port_fs_i   (port_fs_i),
            .port_sd1_i  (port_sd1_i),
            .port_sd2_i  (port_sd2_i),
            .bclk_rx     (ctl_bclk_rx[c]),
            .fs_rx       (ctl_fs_rx[c]),
            .sd1_rx      (ctl_sd1_rx[c]),
            .sd2_rx      (ctl_sd2_rx[c])
        );
    end

endmodule

// File: rtl/audio_xbar_chk.sv
module audio_xbar_chk #(
    parameter int N_PORT = 5,
    parameter int N_CTRL = 3,
    parameter int ADDR_W = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [ADDR_W-1:0]                reg_addr,
    input logic                             reg_we,
    input logic [31:0]                      reg_wdata,
    input logic [31:0]                      reg_rdata,
    input xbar_pkg::port_cfg_t [N_PORT-1:0] port_cfg,
    input xbar_pkg::ctrl_cfg_t [N_CTRL-1:0] ctrl_cfg,
    input logic [N_PORT-1:0]                port_bclk_i,
    input logic [N_PORT-1:0]                port_fs_i,
    input logic [N_PORT-1:0]                port_bclk_o,
    input logic [N_PORT-1:0]                port_bclk_oe,
    input logic [N_PORT-1:0]                port_fs_o,
    input logic [N_PORT-1:0]                port_fs_oe,
    input logic [N_PORT-1:0]                port_sd1_o,
    input logic [N_PORT-1:0]                port_sd1_oe,
    input logic [N_PORT-1:0]                port_sd2_o,
    input logic [N_PORT-1:0]                port_sd2_oe,
    input logic [N_CTRL-1:0]                ctl_bclk_tx,
    input logic [N_CTRL-1:0]                ctl_bclk_rx,
    input logic [N_CTRL-1:0]                ctl_fs_rx
);
    import xbar_pkg::*;

    logic unused_bits;
    assign unused_bits = ^reg_wdata[23:5];

    a_r4_unaligned_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] != 2'b00) |-> (reg_rdata == 32'd0));

    for (genvar p = 0; p < N_PORT; p++) begin : g_pchk
        a_r4_port_write_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(4 * p)) |=>
            (port_cfg[p] == {$past(reg_wdata[31]), $past(reg_wdata[30]),
                             $past(reg_wdata[29]), $past(reg_wdata[4:0])}));

        a_r10_invalid_source_off: assert property (@(posedge clk) disable iff (!rst_n)
            ((int'(port_cfg[p].src) >= N_CTRL) &&
             !((int'(port_cfg[p].src) >= PEER_BASE) &&
               (int'(port_cfg[p].src) < PEER_BASE + N_PORT)))
            |-> ({port_bclk_oe[p], port_fs_oe[p], port_sd1_oe[p], port_sd2_oe[p],
                  port_bclk_o[p], port_fs_o[p], port_sd1_o[p], port_sd2_o[p]} == 8'd0));

        a_r8_master_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            ((int'(port_cfg[p].src) >= PEER_BASE) &&
             (int'(port_cfg[p].src) < PEER_BASE + N_PORT) && port_cfg[p].master)
            |-> (!port_bclk_oe[p] && !port_fs_oe[p]));

        for (genvar c = 0; c < N_CTRL; c++) begin : g_cc
            a_r5_ctrl_clock_routed: assert property (@(posedge clk) disable iff (!rst_n)
                (port_cfg[p].src == SRC_W'(c))
                |-> (port_bclk_oe[p] && (port_bclk_o[p] == ctl_bclk_tx[c])));
        end

        for (genvar q = 0; q < N_PORT; q++) begin : g_pq
            a_r7_slave_clock_follows: assert property (@(posedge clk) disable iff (!rst_n)
                ((port_cfg[p].src == SRC_W'(PEER_BASE + q)) && !port_cfg[p].master)
                |-> (port_bclk_oe[p] && (port_bclk_o[p] == port_bclk_i[q]) &&
                     (port_fs_o[p] == port_fs_i[q])));
        end
    end

    for (genvar c = 0; c < N_CTRL; c++) begin : g_cchk
        a_r4_ctrl_write_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(4 * (CTRL_WORD + c))) |=>
            (ctrl_cfg[c] == {$past(reg_wdata[31:24]), $past(reg_wdata[3:0])}));

        a_r11_absent_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(ctrl_cfg[c].clk_sel) >= N_PORT)
            |-> (!ctl_bclk_rx[c] && !ctl_fs_rx[c]));
    end

endmodule

bind audio_xbar audio_xbar_chk #(
    .N_PORT (N_PORT),
    .N_CTRL (N_CTRL),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .port_cfg     (port_cfg),
    .ctrl_cfg     (ctrl_cfg),
    .port_bclk_i  (port_bclk_i),
    .port_fs_i    (port_fs_i),
    .port_bclk_o  (port_bclk_o),
    .port_bclk_oe (port_bclk_oe),
    .port_fs_o    (port_fs_o),
    .port_fs_oe   (port_fs_oe),
    .port_sd1_o   (port_sd1_o),
    .port_sd1_oe  (port_sd1_oe),
    .port_sd2_o   (port_sd2_o),
    .port_sd2_oe  (port_sd2_oe),
    .ctl_bclk_tx  (ctl_bclk_tx),
    .ctl_bclk_rx  (ctl_bclk_rx),
    .ctl_fs_rx    (ctl_fs_rx)
);

// File: tb/audio_xbar_test.sv
module audio_xbar_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  pb_i = '0, pf_i = '0, p1_i = '0, p2_i = '0;
    logic [4:0]  pb_o, pb_oe, pf_o, pf_oe, p1_o, p1_oe, p2_o, p2_oe;
    logic [2:0]  cb_tx = '0, cf_tx = '0, c1_tx = '0, c2_tx = '0;
    logic [2:0]  cb_rx, cf_rx, c1_rx, c2_rx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    audio_xbar uut (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .port_bclk_i (pb_i), .port_bclk_o (pb_o), .port_bclk_oe (pb_oe),
        .port_fs_i (pf_i), .port_fs_o (pf_o), .port_fs_oe (pf_oe),
        .port_sd1_i (p1_i), .port_sd1_o (p1_o), .port_sd1_oe (p1_oe),
        .port_sd2_i (p2_i), .port_sd2_o (p2_o), .port_sd2_oe (p2_oe),
        .ctl_bclk_tx (cb_tx), .ctl_fs_tx (cf_tx), .ctl_sd1_tx (c1_tx), .ctl_sd2_tx (c2_tx),
        .ctl_bclk_rx (cb_rx), .ctl_fs_rx (cf_rx), .ctl_sd1_rx (c1_rx), .ctl_sd2_rx (c2_rx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        #1;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // R1: reset values of registers and default routing to controller 1
    task automatic t_reset();
        cb_tx = 3'b001; cf_tx = 3'b000; c1_tx = 3'b001; c2_tx = 3'b000;
        #1;
        for (int p = 0; p < 5; p++) rd_check("R1 port reg", 8'(4 * p), 32'd0);
        for (int c = 0; c < 3; c++) rd_check("R1 ctrl reg", 8'(8'h40 + 4 * c), 32'd0);
        check("R1 enables", {pb_oe, pf_oe, p1_oe, p2_oe}, {20{1'b1}});
        check("R1 outputs", {pb_o, pf_o, p1_o, p2_o}, {5'b11111, 5'b00000, 5'b11111, 5'b00000});
    endtask

    // R2 R3 R4: field layout, write timing, unmapped addresses
    task automatic t_regmap();
        wr(8'h08, 32'hFFFF_FFFF);
        rd_check("R2 port field mask", 8'h08, 32'hE000_001F);
        wr(8'h44, 32'hFFFF_FFFF);
        rd_check("R3 ctrl field mask", 8'h44, 32'hFF00_000F);
        @(negedge clk);
        reg_addr = 8'h0C; reg_wdata = 32'h8000_0010; reg_we = 1'b1;
        #1;
        check("R4 before edge", reg_rdata, 32'd0);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check("R4 after edge", reg_rdata, 32'h8000_0010);
        wr(8'h41, 32'h1234_5678);
        rd_check("R4 unaligned write ignored", 8'h40, 32'd0);
        rd_check("R4 unaligned read", 8'h41, 32'd0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_check("R4 gap read", 8'h14, 32'd0);
        rd_check("R4 neighbour untouched", 8'h10, 32'd0);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd_check("R4 past ctrl read", 8'h4C, 32'd0);
        rd_check("R4 last ctrl untouched", 8'h48, 32'd0);
    endtask

    // R5: port 0 follows controller 2 with data line 1 receiving
    task automatic t_ctrl_src();
        wr(8'h00, 32'h4000_0001);
        cb_tx = 3'b010; cf_tx = 3'b010; c1_tx = 3'b010; c2_tx = 3'b010;
        #1;
        check("R5 clock pins", {pb_oe[0], pb_o[0], pf_oe[0], pf_o[0]}, 4'b1111);
        check("R5 rx line off", {p1_oe[0], p1_o[0]}, 2'b00);
        check("R5 tx line", {p2_oe[0], p2_o[0]}, 2'b11);
        c2_tx = 3'b000;
        #1;
        check("R5 same-cycle data", {p2_oe[0], p2_o[0]}, 2'b10);
    endtask

    // R6: three ports share controller 3
    task automatic t_broadcast();
        wr(8'h04, 32'h2); wr(8'h0C, 32'h2); wr(8'h10, 32'h2);
        cb_tx = 3'b100; c1_tx = 3'b100;
        #1;
        check("R6 bclk fanout", pb_o & 5'b11010, 5'b11010);
        check("R6 sd1 fanout", p1_o & 5'b11010, 5'b11010);
        cb_tx = 3'b000;
        #1;
        check("R6 bclk fanout low", pb_o & 5'b11010, 5'b00000);
    endtask

    // R7 R8 R9: peer links
    task automatic t_peer();
        wr(8'h0C, 32'h2000_0010);  // port 4 <- port 1, slave, line 2 rx
        pb_i = 5'b00001; pf_i = 5'b00000; p1_i = 5'b00001; p2_i = 5'b00001;
        #1;
        check("R7 slave clock", {pb_oe[3], pb_o[3], pf_oe[3], pf_o[3]}, 4'b1110);
        pf_i = 5'b00001;
        #1;
        check("R7 frame sync follows", pf_o[3], 1'b1);
        check("R9 tx line", {p1_oe[3], p1_o[3]}, 2'b11);
        check("R9 rx line", {p2_oe[3], p2_o[3]}, 2'b00);
        wr(8'h00, 32'h8000_0013);  // port 1 <- port 4, master
        p1_i = 5'b01000;
        #1;
        check("R8 master clock quiet", {pb_oe[0], pb_o[0], pf_oe[0], pf_o[0]}, 4'b0000);
        check("R9 master data", {p1_oe[0], p1_o[0]}, 2'b11);
    endtask

    // R10: invalid source codes, plus last valid peer code
    task automatic t_invalid();
        pb_i = '1; pf_i = '1; p1_i = '1; p2_i = '1;
        cb_tx = '1; cf_tx = '1; c1_tx = '1; c2_tx = '1;
        wr(8'h10, 32'd3);
        check("R10 code 3", {pb_oe[4], pf_oe[4], p1_oe[4], p2_oe[4], pb_o[4], pf_o[4], p1_o[4], p2_o[4]}, 8'd0);
        wr(8'h10, 32'd15);
        check("R10 code 15", {pb_oe[4], pf_oe[4], p1_oe[4], p2_oe[4], pb_o[4], pf_o[4], p1_o[4], p2_o[4]}, 8'd0);
        wr(8'h10, 32'd21);
        check("R10 code 21", {pb_oe[4], pf_oe[4], p1_oe[4], p2_oe[4], pb_o[4], pf_o[4], p1_o[4], p2_o[4]}, 8'd0);
        wr(8'h10, 32'd20);
        check("R10 code 20 valid", {pb_oe[4], pb_o[4]}, 2'b11);
    endtask

    // R11: controller input selection
    task automatic t_ctrl_in();
        wr(8'h40, 32'h0200_0004);  // clock <- port 5, sd1 <- port 3, sd2 <- port 1
        pb_i = 5'b10000; pf_i = 5'b10000; p1_i = 5'b00100; p2_i = 5'b00001;
        #1;
        check("R11 selected high", {cb_rx[0], cf_rx[0], c1_rx[0], c2_rx[0]}, 4'b1111);
        pb_i = 5'b01111; pf_i = 5'b01111; p1_i = 5'b11011; p2_i = 5'b11110;
        #1;
        check("R11 selected low", {cb_rx[0], cf_rx[0], c1_rx[0], c2_rx[0]}, 4'b0000);
        pb_i = '1; pf_i = '1; p1_i = '1; p2_i = '1;
        wr(8'h40, 32'h5500_0005);
        check("R11 sel 5 absent", {cb_rx[0], cf_rx[0], c1_rx[0], c2_rx[0]}, 4'b0000);
        check("R11 sel 15 absent", {cb_rx[1], cf_rx[1], c1_rx[1], c2_rx[1]}, 4'b0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_ctrl_src();
        t_broadcast();
        t_peer();
        t_invalid();
        t_ctrl_in();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule